// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Bank

This block holds the programmable state of a 64-source interrupt controller that has two request outputs, a normal one and a fast one. Software reaches it through a word-addressed synchronous bus with separate read and write strobes. Through that bus it sets a control word and a normal-priority threshold. It can switch sources on one at a time by writing a source number, or it can write whole 32-bit halves of the enable vector. It picks the fast or normal path for each source, gives each source a 4-bit priority, and can force pending bits directly. Each source has a level input. A high level sets the source's pending bit, and a falling edge on that input clears it.

Two vector words acknowledge requests when read. A read of the normal vector word returns the highest-priority active normal source, with ties going to the highest source number, and clears its pending bit. A read of the fast vector word returns the lowest-numbered active fast source and clears its pending bit. A priority resolver tree picks the normal winner. A first-set finder picks the fast winner. A threshold gate drives the normal request output.

The bus has no back-pressure. Every strobe is taken in the cycle it is presented, and read data is registered, so it is valid in the cycle after a read strobe. The bus signals are control pins and carry no valid/ready handshake.

Top module: `irq_regbank`

## Requirements
- R1: After reset, the mask word (offset 1) reads 0x1F, every other stored word reads zero, and both request outputs are low.
- R2: A write to offset 1 keeps only data bits 4:0. A write to offset 0 keeps only the bits set in parameter CTRL_KEEP (default 0x3F). Both read back the stored value.
- R3: A write to offset 2 sets the enable bit selected by data bits 5:0. A write to offset 3 clears that bit. Both offsets read zero.
- R4: Offsets 4 and 5 read and write the enable vector for sources 63..32 and 31..0. Offsets 6 and 7 do the same for the type vector, where a type bit of 1 routes that source to the fast path.
- R5: Offsets 8 to 15 are the priority words in reverse order. Offset 15 holds sources 0..7 and offset 8 holds sources 56..63. Source s sits in bits 4*(s%8)+3 : 4*(s%8) of its word.
- R6: Reading offset 16 returns (source<<16)|priority for the highest-priority active normal source (pending, enabled, type 0), with ties going to the highest source number, and clears that source's pending bit. With no active normal source it returns 0xFFFFFFFF.
- R7: Reading offset 17 returns the number of the lowest active fast source (pending, enabled, type 1) and clears its pending bit. With no active fast source it returns 0xFFFFFFFF.
- R8: Offsets 18 and 19 read the raw pending bits 63..32 and 31..0. A write to offset 20 or 21 replaces that half of the pending vector. Offsets 20 and 21 read zero.
- R9: Offsets 22 and 23 read the active normal sources (upper half, then lower half), and offsets 24 and 25 read the active fast sources. Writes to offsets 16 to 19 and 22 to 25 change nothing.
- R10: Offset 0x40 reads 4. Writes to offsets 0x40 to 0xBF change nothing. Any other unmapped offset reads zero.
- R11: A high source level sets its pending bit at each clock edge, and a high-to-low change clears it. When an acknowledge clear and a high level fall in the same cycle, the clear wins, and the bit is set again at the next edge if the level stays high.
- R12: Read data is registered and appears in the cycle after the read strobe. The acknowledge clear takes effect at that same clock edge.
- R13: The fast output is high exactly when some fast source is active. The normal output is high when some normal source is active and either the mask equals 0x1F or at least one active normal source has a priority strictly above the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 10 | Word offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, also triggers acknowledge on offsets 16 and 17 |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| src_level | input | 64 | Per-source request levels |
| nirq_o | output | 1 | Normal interrupt request |
| firq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is the collision in R11, where an acknowledge clear and a still-high source level hit the same bit at the same clock edge. From the ports, that collision shows up only as a one-cycle hole in the pending bit. The bench holds a level high and acknowledges that source through offset 16. It then reads the raw pending word on each of the next two consecutive edges, and it expects the bit to be clear on the first read and set again on the second. Tie-breaking in the normal resolver is reached by forcing pending bits so that two sources share one priority level while a third sits lower, and then draining them one read at a time.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int NSRC         = 64;
  localparam int DW           = 32;
  localparam int PW           = 4;
  localparam int AW           = 10;
  localparam int MASK_W       = 5;
  localparam int HALF         = NSRC / 2;
  localparam int IW           = $clog2(NSRC);
  localparam int PRIO_WORDS   = (NSRC * PW) / DW;
  localparam int PWI          = $clog2(PRIO_WORDS);
  localparam int VEC_SHIFT    = 16;

  localparam logic [AW-1:0] OFF_CTRL    = 10'd0;
  localparam logic [AW-1:0] OFF_MASK    = 10'd1;
  localparam logic [AW-1:0] OFF_ENNUM   = 10'd2;
  localparam logic [AW-1:0] OFF_DISNUM  = 10'd3;
  localparam logic [AW-1:0] OFF_EN_HI   = 10'd4;
  localparam logic [AW-1:0] OFF_EN_LO   = 10'd5;
  localparam logic [AW-1:0] OFF_TY_HI   = 10'd6;
  localparam logic [AW-1:0] OFF_TY_LO   = 10'd7;
  localparam logic [AW-1:0] OFF_PRIO0   = 10'd8;
  localparam logic [AW-1:0] OFF_PRIO_L  = 10'd15;
  localparam logic [AW-1:0] OFF_NVEC    = 10'd16;
  localparam logic [AW-1:0] OFF_FVEC    = 10'd17;
  localparam logic [AW-1:0] OFF_RAW_HI  = 10'd18;
  localparam logic [AW-1:0] OFF_RAW_LO  = 10'd19;
  localparam logic [AW-1:0] OFF_FRC_HI  = 10'd20;
  localparam logic [AW-1:0] OFF_FRC_LO  = 10'd21;
  localparam logic [AW-1:0] OFF_NACT_HI = 10'd22;
  localparam logic [AW-1:0] OFF_NACT_LO = 10'd23;
  localparam logic [AW-1:0] OFF_FACT_HI = 10'd24;
  localparam logic [AW-1:0] OFF_FACT_LO = 10'd25;
  localparam logic [AW-1:0] OFF_CONST   = 10'h040;

  localparam logic [DW-1:0] CONST_VAL   = 32'd4;
  localparam logic [DW-1:0] NO_WINNER   = '1;
endpackage

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
  parameter int N  = 64,
  parameter int PW = 4
) (
  input  logic [N-1:0]         req,
  input  logic [N*PW-1:0]      prio,
  output logic                 hit,
  output logic [$clog2(N)-1:0] idx,
  output logic [PW-1:0]        lvl
);
  localparam int IW    = $clog2(N);
  localparam int P     = 1 << IW;
  localparam int NODES = 2 * P - 1;

  logic          nv [NODES];
  logic [IW-1:0] ni [NODES];
  logic [PW-1:0] np [NODES];

  for (genvar g = 0; g < P; g++) begin : g_leaf
    if (g < N) begin : g_real
      assign nv[P-1+g] = req[g];
      assign ni[P-1+g] = IW'(g);
      assign np[P-1+g] = prio[g*PW +: PW];
    end else begin : g_pad
      assign nv[P-1+g] = 1'b0;
      assign ni[P-1+g] = '0;
      assign np[P-1+g] = '0;
    end
  end

  // Right child covers higher source numbers; it wins ties.
  for (genvar g = 0; g < P - 1; g++) begin : g_node
    logic pick_r;
    assign pick_r = nv[2*g+2] && (!nv[2*g+1] || (np[2*g+2] >= np[2*g+1]));
    assign nv[g]  = nv[2*g+1] | nv[2*g+2];
    assign ni[g]  = pick_r ? ni[2*g+2] : ni[2*g+1];
    assign np[g]  = pick_r ? np[2*g+2] : np[2*g+1];
  end

  assign hit = nv[0];
  assign idx = ni[0];
  assign lvl = np[0];
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int N = 64
) (
  input  logic [N-1:0]         req,
  output logic                 hit,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign hit = |req;
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
  parameter int N  = 64,
  parameter int PW = 4,
  parameter int MW = 5
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  input  logic [MW-1:0]   mask,
  output logic            req_out
);
  logic [N-1:0] above;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign above[g] = MW'(prio[g*PW +: PW]) > mask;
  end

  assign req_out = (&mask) ? (|req) : (|(req & above));
endmodule

// File: rtl/irq_pend_ctl.sv
module irq_pend_ctl #(
  parameter int N = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   level,
  input  logic [N-1:0]   ack_clr,
  input  logic           force_hi,
  input  logic           force_lo,
  input  logic [N/2-1:0] force_data,
  output logic [N-1:0]   pend
);
  localparam int HW = N / 2;

  logic [N-1:0] lvl_q;
  logic [N-1:0] nxt;

  always_comb begin
    nxt = pend | level;
    nxt = nxt & ~(lvl_q & ~level);
    nxt = nxt & ~ack_clr;
    if (force_hi) nxt[N-1:HW] = force_data;
    if (force_lo) nxt[HW-1:0] = force_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      lvl_q <= '0;
    end else begin
      pend  <= nxt;
      lvl_q <= level;
    end
  end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_regs_pkg::*;
#(
  parameter logic [DW-1:0]     CTRL_KEEP = 32'h0000_003F,
  parameter logic [MASK_W-1:0] MASK_RST  = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_rd,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_level,
  output logic            nirq_o,
  output logic            firq_o
);
  logic [DW-1:0]      ctrl_q;
  logic [MASK_W-1:0]  mask_q;
  logic [NSRC-1:0]    en_q;
  logic [NSRC-1:0]    fast_q;
  logic [NSRC*PW-1:0] prio_q;
  logic [NSRC-1:0]    pend;

  logic [NSRC-1:0] act_n;
  logic [NSRC-1:0] act_f;
  logic            n_hit;
  logic [IW-1:0]   n_idx;
  logic [PW-1:0]   n_lvl;
  logic            f_hit;
  logic [IW-1:0]   f_idx;

  logic            in_prio;
  logic [PWI-1:0]  pw_sel;
  logic            ack_n;
  logic            ack_f;
  logic [NSRC-1:0] ack_clr;
  logic            frc_hi;
  logic            frc_lo;
  logic [DW-1:0]   rd_mux;

  assign act_n = pend & en_q & ~fast_q;
  assign act_f = pend & en_q & fast_q;

  irq_prio_tree #(.N(NSRC), .PW(PW)) u_tree (
    .req  (act_n),
    .prio (prio_q),
    .hit  (n_hit),
    .idx  (n_idx),
    .lvl  (n_lvl)
  );

  irq_first_set #(.N(NSRC)) u_first (
    .req (act_f),
    .hit (f_hit),
    .idx (f_idx)
  );

  irq_mask_gate #(.N(NSRC), .PW(PW), .MW(MASK_W)) u_gate (
    .req     (act_n),
    .prio    (prio_q),
    .mask    (mask_q),
    .req_out (nirq_o)
  );

  assign firq_o = |act_f;

  // Priority words are mapped in reverse: lowest offset holds the top sources.
  assign in_prio = (bus_addr >= OFF_PRIO0) && (bus_addr <= OFF_PRIO_L);
  assign pw_sel  = PWI'(PRIO_WORDS - 1) - PWI'(bus_addr - OFF_PRIO0);

  assign ack_n   = bus_rd && (bus_addr == OFF_NVEC) && n_hit;
  assign ack_f   = bus_rd && (bus_addr == OFF_FVEC) && f_hit;
  assign ack_clr = (ack_n ? (NSRC'(1) << n_idx) : '0)
                 | (ack_f ? (NSRC'(1) << f_idx) : '0);
  assign frc_hi  = bus_wr && (bus_addr == OFF_FRC_HI);
  assign frc_lo  = bus_wr && (bus_addr == OFF_FRC_LO);

  irq_pend_ctl #(.N(NSRC)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (src_level),
    .ack_clr    (ack_clr),
    .force_hi   (frc_hi),
    .force_lo   (frc_lo),
    .force_data (bus_wdata[HALF-1:0]),
    .pend       (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= MASK_RST;
      en_q   <= '0;
      fast_q <= '0;
      prio_q <= '0;
    end else if (bus_wr) begin
      if (in_prio) begin
        prio_q[int'(pw_sel)*DW +: DW] <= bus_wdata;
      end else begin
        case (bus_addr)
          OFF_CTRL:   ctrl_q <= bus_wdata & CTRL_KEEP;
          OFF_MASK:   mask_q <= bus_wdata[MASK_W-1:0];
          OFF_ENNUM:  en_q[bus_wdata[IW-1:0]] <= 1'b1;
          OFF_DISNUM: en_q[bus_wdata[IW-1:0]] <= 1'b0;
          OFF_EN_HI:  en_q[NSRC-1:HALF] <= bus_wdata[HALF-1:0];
          OFF_EN_LO:  en_q[HALF-1:0] <= bus_wdata[HALF-1:0];
          OFF_TY_HI:  fast_q[NSRC-1:HALF] <= bus_wdata[HALF-1:0];
          OFF_TY_LO:  fast_q[HALF-1:0] <= bus_wdata[HALF-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_prio) begin
      rd_mux = prio_q[int'(pw_sel)*DW +: DW];
    end else begin
      case (bus_addr)
        OFF_CTRL:    rd_mux = ctrl_q;
        OFF_MASK:    rd_mux = DW'(mask_q);
        OFF_EN_HI:   rd_mux = DW'(en_q[NSRC-1:HALF]);
        OFF_EN_LO:   rd_mux = DW'(en_q[HALF-1:0]);
        OFF_TY_HI:   rd_mux = DW'(fast_q[NSRC-1:HALF]);
        OFF_TY_LO:   rd_mux = DW'(fast_q[HALF-1:0]);
        OFF_NVEC:    rd_mux = n_hit ? ((DW'(n_idx) << VEC_SHIFT) | DW'(n_lvl)) : NO_WINNER;
        OFF_FVEC:    rd_mux = f_hit ? DW'(f_idx) : NO_WINNER;
        OFF_RAW_HI:  rd_mux = DW'(pend[NSRC-1:HALF]);
        OFF_RAW_LO:  rd_mux = DW'(pend[HALF-1:0]);
        OFF_NACT_HI: rd_mux = DW'(act_n[NSRC-1:HALF]);
        OFF_NACT_LO: rd_mux = DW'(act_n[HALF-1:0]);
        OFF_FACT_HI: rd_mux = DW'(act_f[NSRC-1:HALF]);
        OFF_FACT_LO: rd_mux = DW'(act_f[HALF-1:0]);
        OFF_CONST:   rd_mux = CONST_VAL;
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk
  import irq_regs_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [AW-1:0]        bus_addr,
  input logic                 bus_wr,
  input logic [DW-1:0]        bus_wdata,
  input logic                 bus_rd,
  input logic [DW-1:0]        bus_rdata,
  input logic [MASK_W-1:0]    mask_q,
  input logic                 n_hit,
  input logic                 f_hit,
  input logic [IW-1:0]        f_idx,
  input logic [NSRC-1:0]      pend,
  input logic                 firq_o
);
  // R2
  a_r2_mask_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFF_MASK |=> mask_q == $past(bus_wdata[MASK_W-1:0]));

  // R3
  a_r3_num_words_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr == OFF_ENNUM || bus_addr == OFF_DISNUM) |=> bus_rdata == '0);

  // R6
  a_r6_empty_normal: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == OFF_NVEC && !n_hit |=> bus_rdata == NO_WINNER);

  // R7, R12
  a_r7_fast_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && bus_addr == OFF_FVEC && f_hit |=> !pend[$past(f_idx)]);

  // R10
  a_r10_const_word: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == OFF_CONST |=> bus_rdata == CONST_VAL);

  // R13
  a_r13_fast_line: assert property (@(posedge clk) disable iff (!rst_n)
    firq_o == f_hit);

  // R12
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind irq_regbank irq_regbank_chk u_chk (.*);

// File: tb/irq_regbank_tb.sv
module irq_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [63:0] src_level = '0;
  logic        nirq_o;
  logic        firq_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  irq_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .src_level(src_level), .nirq_o(nirq_o), .firq_o(firq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check("R1 nirq", {31'd0, nirq_o}, 32'd0);
    check("R1 firq", {31'd0, firq_o}, 32'd0);
    rd_chk(10'd1, 32'h1F, "R1 mask reset");
    rd_chk(10'd5, 32'h0, "R1 enable reset");
    rd_chk(10'd15, 32'h0, "R1 prio reset");
    rd_chk(10'd19, 32'h0, "R1 pending reset");
  endtask

  task automatic t_mask_ctrl;
    wr(10'd1, 32'hFFFF_FFEA);
    rd_chk(10'd1, 32'h0A, "R2 mask keeps low bits");
    wr(10'd0, 32'hFFFF_FFFF);
    rd_chk(10'd0, 32'h3F, "R2 ctrl keep mask");
    wr(10'd1, 32'h1F);
  endtask

  task automatic t_enable_num;
    wr(10'd2, 32'h45);
    rd_chk(10'd5, 32'h20, "R3 enable by number");
    wr(10'd2, 32'd63);
    rd_chk(10'd4, 32'h8000_0000, "R3 enable source 63");
    rd_chk(10'd2, 32'h0, "R3 enable word reads zero");
    rd_chk(10'd3, 32'h0, "R3 disable word reads zero");
    wr(10'd3, 32'd5);
    rd_chk(10'd5, 32'h0, "R3 disable by number");
  endtask

  task automatic t_halves;
    wr(10'd4, 32'hA5A5_0000);
    wr(10'd5, 32'h0000_1234);
    rd_chk(10'd4, 32'hA5A5_0000, "R4 enable upper");
    rd_chk(10'd5, 32'h0000_1234, "R4 enable lower");
    wr(10'd6, 32'h0F0F_0F0F);
    wr(10'd7, 32'h8000_0001);
    rd_chk(10'd6, 32'h0F0F_0F0F, "R4 type upper");
    rd_chk(10'd7, 32'h8000_0001, "R4 type lower");
    wr(10'd4, 32'h0); wr(10'd5, 32'h0); wr(10'd6, 32'h0); wr(10'd7, 32'h0);
  endtask

  task automatic t_prio;
    wr(10'd15, 32'h0000_0003);
    wr(10'd8, 32'h7000_0000);
    rd_chk(10'd15, 32'h0000_0003, "R5 offset 15 sources 0..7");
    rd_chk(10'd8, 32'h7000_0000, "R5 offset 8 sources 56..63");
    rd_chk(10'd14, 32'h0, "R5 untouched word");
    wr(10'd8, 32'h0);
  endtask

  task automatic t_normal;
    wr(10'd4, 32'hFFFF_FFFF);
    wr(10'd5, 32'hFFFF_FFFF);
    wr(10'd15, 32'h0000_5000);  // source 3 prio 5
    wr(10'd14, 32'h0000_0500);  // source 10 prio 5
    wr(10'd10, 32'h0000_0002);  // source 40 prio 2
    wr(10'd21, (32'd1 << 3) | (32'd1 << 10));
    wr(10'd20, 32'd1 << 8);
    rd_chk(10'd23, 32'h0000_0408, "R9 normal active low");
    check("R13 nirq unmasked", {31'd0, nirq_o}, 32'd1);
    wr(10'd1, 32'd4);
    check("R13 nirq above mask", {31'd0, nirq_o}, 32'd1);
    wr(10'd1, 32'd5);
    check("R13 nirq equal to mask blocked", {31'd0, nirq_o}, 32'd0);
    wr(10'd1, 32'h1F);
    rd_chk(10'd20, 32'h0, "R8 force reads zero");
    rd_chk(10'd16, (32'd10 << 16) | 32'd5, "R6 tie goes to higher source");
    rd_chk(10'd19, 32'd1 << 3, "R6 ack cleared source 10");
    rd_chk(10'd16, (32'd3 << 16) | 32'd5, "R6 next winner");
    rd_chk(10'd16, (32'd40 << 16) | 32'd2, "R6 low priority last");
    rd_chk(10'd18, 32'h0, "R8 raw upper after ack");
    rd_chk(10'd16, 32'hFFFF_FFFF, "R6 no winner");
    check("R13 nirq idle", {31'd0, nirq_o}, 32'd0);
  endtask

  task automatic t_fast;
    wr(10'd7, (32'd1 << 7) | (32'd1 << 20));
    wr(10'd21, (32'd1 << 7) | (32'd1 << 20));
    rd_chk(10'd25, (32'd1 << 7) | (32'd1 << 20), "R9 fast active low");
    rd_chk(10'd23, 32'h0, "R9 fast not in normal");
    check("R13 firq high", {31'd0, firq_o}, 32'd1);
    check("R13 nirq low with only fast", {31'd0, nirq_o}, 32'd0);
    rd_chk(10'd17, 32'd7, "R7 lowest fast first");
    rd_chk(10'd17, 32'd20, "R7 second fast");
    rd_chk(10'd17, 32'hFFFF_FFFF, "R7 no fast winner");
    check("R13 firq low", {31'd0, firq_o}, 32'd0);
    wr(10'd7, 32'h0);
  endtask

  task automatic t_ro_writes;
    wr(10'd19, 32'hFFFF_FFFF);
    wr(10'd18, 32'hFFFF_FFFF);
    wr(10'd16, 32'hFFFF_FFFF);
    wr(10'd23, 32'hFFFF_FFFF);
    wr(10'd25, 32'hFFFF_FFFF);
    rd_chk(10'd19, 32'h0, "R9 writes to read-only lower");
    rd_chk(10'd18, 32'h0, "R9 writes to read-only upper");
    rd_chk(10'd1, 32'h1F, "R9 mask untouched");
  endtask

  task automatic t_vecspace;
    rd_chk(10'h040, 32'd4, "R10 constant word");
    wr(10'h041, 32'h0);
    wr(10'h043, 32'h0);
    wr(10'h0BF, 32'h0);
    rd_chk(10'd1, 32'h1F, "R10 vector space write ignored");
    rd_chk(10'd5, 32'hFFFF_FFFF, "R10 enable untouched");
    rd_chk(10'h030, 32'h0, "R10 unmapped reads zero");
    rd_chk(10'h3FF, 32'h0, "R10 top offset reads zero");
  endtask

  task automatic t_level;
    @(negedge clk);
    src_level[2] = 1'b1;
    @(posedge clk);
    rd_chk(10'd19, 32'd1 << 2, "R11 level sets pending");
    rd_chk(10'd16, 32'd2 << 16, "R12 ack with level high");
    rd_chk(10'd19, 32'h0, "R11 clear wins collision");
    rd_chk(10'd19, 32'd1 << 2, "R11 set again next edge");
    @(negedge clk);
    src_level[2] = 1'b0;
    @(posedge clk);
    rd_chk(10'd19, 32'h0, "R11 falling edge clears");
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_mask_ctrl;
    t_enable_num;
    t_halves;
    t_prio;
    t_normal;
    t_fast;
    t_ro_writes;
    t_vecspace;
    t_level;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule